// File: doc/BRIEF.md
# Integer Shift and Rotate Unit

A purely combinational datapath slice for the execute stage of a 32-bit integer pipeline. It receives the already-split fields of a register-format instruction (function code, 5-bit shift-amount field, and one spare bit of the rs field) together with the two source operand values. It returns the destination value for the shift group: left logical, right logical, right arithmetic and right rotate.

Each shift comes in two forms. The immediate form takes its distance from the sa field. The variable form takes its distance from the low five bits of the rs operand value. Rotation reuses the function codes of the logical right shifts. It is selected by a spare bit: rs field bit 0 for the immediate form, and sa field bit 0 for the variable form.

A single log-depth barrel network serves every operation. Left shifts are built by bit-reversing around a right shifter. The bits that enter from the top are zero, copies of the sign, or the bits that wrap around, depending on the operation. A valid flag tells the surrounding decode whether the function code belongs to this group.

Top module: `shift_unit`

## Requirements
- R1: Function code 0x00 returns rt shifted left by sa, with zeros entering at bit 0.
- R2: Function code 0x02 with rs_rot_i = 0 returns rt shifted right logically by sa, with zeros entering at bit 31.
- R3: Function code 0x02 with rs_rot_i = 1 returns rt rotated right by sa. Bits leaving at bit 0 re-enter at bit 31.
- R4: Function code 0x03 returns rt shifted right by sa, with copies of rt bit 31 entering at the top.
- R5: Function codes 0x04, 0x06 and 0x07 perform left, logical-right and arithmetic-right shifts respectively, by rs_val_i[4:0]. Bits 31..5 of rs_val_i have no effect.
- R6: Function code 0x06 rotates right by rs_val_i[4:0] when sa_i bit 0 is 1, and shifts right logically when it is 0.
- R7: A rotate by a distance of zero, in either form, returns rt unchanged.
- R8: valid_o is 1 exactly for function codes 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07. For every other code, valid_o is 0 and rd_o is zero.
- R9: The all-zero encoding (function 0x00, sa 0, rt 0) yields rd_o = 0 and valid_o = 1.
- R10: rs_rot_i affects only function code 0x02. The sa field affects neither 0x04 nor 0x07, and affects 0x06 only through bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funct_i | input | 6 | Function code field |
| sa_i | input | 5 | Shift-amount field; bit 0 also selects variable rotate |
| rs_rot_i | input | 1 | Bit 0 of the rs field; selects immediate rotate |
| rs_val_i | input | 32 | rs operand value; low 5 bits give the variable distance |
| rt_val_i | input | 32 | rt operand value, the data being shifted |
| rd_o | output | 32 | Result value |
| valid_o | output | 1 | Function code belongs to the shift group |

## Verification
The bench builds the unit with its default 32-bit width and 5-bit distance. At this size, every distance from 0 to 31 can be swept for every operation and both amount sources. This covers the rotate-by-zero edge, the full-width wrap at 31, and sign fill from both signs of rt. Scrambled upper bits of rs and unused selector bits then show that only the documented bits steer the result.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_SLL,
    K_SRL,
    K_SRA,
    K_ROR
  } kind_e;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_SIGN,
    FILL_WRAP
  } fill_e;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
(
  input  logic [5:0] funct_i,
  input  logic       rs_rot_i,
  input  logic       sa_rot_i,
  output kind_e      kind_o,
  output logic       var_o,
  output logic       valid_o
);
  always_comb begin
    kind_o  = K_NONE;
    var_o   = 1'b0;
    valid_o = 1'b1;
    unique case (funct_i)
      FN_SLL:  kind_o = K_SLL;
      FN_SRL:  kind_o = rs_rot_i ? K_ROR : K_SRL;
      FN_SRA:  kind_o = K_SRA;
      FN_SLLV: begin kind_o = K_SLL; var_o = 1'b1; end
      FN_SRLV: begin kind_o = sa_rot_i ? K_ROR : K_SRL; var_o = 1'b1; end
      FN_SRAV: begin kind_o = K_SRA; var_o = 1'b1; end
      default: valid_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!valid_o) p_none_when_idle_r8: assert (kind_o == K_NONE);
  end
endmodule

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            var_i,
  input  logic [SHW-1:0]  sa_i,
  input  logic [XLEN-1:0] rs_val_i,
  output logic [SHW-1:0]  amt_o
);
  logic unused_rs_hi;
  assign unused_rs_hi = ^rs_val_i[XLEN-1:SHW];
  assign amt_o = var_i ? rs_val_i[SHW-1:0] : sa_i;
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
  import shift_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  fill_e           fill_i,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] data_rev, src, net, net_rev;

  // left shift = reverse, shift right, reverse back
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign data_rev[i] = data_i[XLEN-1-i];
    assign net_rev[i]  = net[XLEN-1-i];
  end

  assign src = left_i ? data_rev : data_i;

  always_comb begin
    logic [XLEN-1:0] cur, nxt;
    logic            sign_b;
    sign_b = data_i[XLEN-1];
    cur    = src;
    for (int k = 0; k < SHW; k++) begin
      nxt = cur;
      if (amt_i[k]) begin
        for (int i = 0; i < XLEN; i++) begin
          if (i + (1 << k) < XLEN) begin
            nxt[i] = cur[i + (1 << k)];
          end else begin
            unique case (fill_i)
              FILL_SIGN: nxt[i] = sign_b;
              FILL_WRAP: nxt[i] = cur[i + (1 << k) - XLEN];
              default:   nxt[i] = 1'b0;
            endcase
          end
        end
      end
      cur = nxt;
    end
    net = cur;
  end

  assign data_o = left_i ? net_rev : net;

  always_comb begin
    if (amt_i == '0) p_zero_dist_passes_r7: assert (data_o == data_i);
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [5:0]      funct_i,
  input  logic [SHW-1:0]  sa_i,
  input  logic            rs_rot_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] rd_o,
  output logic            valid_o
);
  kind_e           kind;
  logic            var_sel;
  logic            dec_valid;
  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] bar_out;
  fill_e           fill;

  shift_decode u_dec (
    .funct_i  (funct_i),
    .rs_rot_i (rs_rot_i),
    .sa_rot_i (sa_i[0]),
    .kind_o   (kind),
    .var_o    (var_sel),
    .valid_o  (dec_valid)
  );

  shift_amt_sel #(.XLEN(XLEN)) u_amt (
    .var_i    (var_sel),
    .sa_i     (sa_i),
    .rs_val_i (rs_val_i),
    .amt_o    (amt)
  );

  always_comb begin
    unique case (kind)
      K_SRA:   fill = FILL_SIGN;
      K_ROR:   fill = FILL_WRAP;
      default: fill = FILL_ZERO;
    endcase
  end

  shift_barrel #(.XLEN(XLEN)) u_bar (
    .data_i (rt_val_i),
    .amt_i  (amt),
    .left_i (kind == K_SLL),
    .fill_i (fill),
    .data_o (bar_out)
  );

  assign valid_o = dec_valid;
  assign rd_o    = dec_valid ? bar_out : '0;

  logic [XLEN-1:0] low_mask;
  assign low_mask = (XLEN'(1) << amt) - XLEN'(1);

  always_comb begin
    if (!valid_o) p_idle_result_zero_r8: assert (rd_o == '0);
    if (kind == K_ROR)
      p_rotate_keeps_ones_r3: assert ($countones(rd_o) == $countones(rt_val_i));
    if (kind == K_SLL) p_left_low_zero_r1: assert ((rd_o & low_mask) == '0);
    if (kind == K_SRA) p_arith_sign_kept_r4: assert (rd_o[XLEN-1] == rt_val_i[XLEN-1]);
  end
endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
  logic        clk = 1'b0;
  logic [5:0]  funct;
  logic [4:0]  sa;
  logic        rs_rot;
  logic [31:0] rs_val, rt_val;
  logic [31:0] rd;
  logic        valid;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  shift_unit u_shift_unit (
    .funct_i  (funct),
    .sa_i     (sa),
    .rs_rot_i (rs_rot),
    .rs_val_i (rs_val),
    .rt_val_i (rt_val),
    .rd_o     (rd),
    .valid_o  (valid)
  );

  function automatic logic [31:0] ror(input logic [31:0] v, input logic [4:0] n);
    if (n == 0) return v;
    return (v << (6'd32 - {1'b0, n})) | (v >> n);
  endfunction

  function automatic logic [32:0] model(input logic [5:0] f, input logic [4:0] s,
                                        input logic r, input logic [31:0] a, input logic [31:0] t);
    logic [4:0] vn;
    vn = a[4:0];
    case (f)
      6'h00: return {1'b1, t << s};
      6'h02: return {1'b1, r ? ror(t, s) : t >> s};
      6'h03: return {1'b1, 32'($signed(t) >>> s)};
      6'h04: return {1'b1, t << vn};
      6'h06: return {1'b1, s[0] ? ror(t, vn) : t >> vn};
      6'h07: return {1'b1, 32'($signed(t) >>> vn)};
      default: return 33'd0;
    endcase
  endfunction

  task automatic apply(input string req, input logic [5:0] f, input logic [4:0] s,
                       input logic r, input logic [31:0] a, input logic [31:0] t);
    logic [32:0] exp;
    @(negedge clk);
    funct = f; sa = s; rs_rot = r; rs_val = a; rt_val = t;
    exp = model(f, s, r, a, t);
    #2;
    total++;
    if ({valid, rd} !== exp) begin
      bad++;
      $display("FAIL %s funct=%h sa=%0d rot=%b rs=%h rt=%h: got v=%b rd=%h exp v=%b rd=%h",
               req, f, s, r, a, t, valid, rd, exp[32], exp[31:0]);
    end
  endtask

  localparam logic [31:0] PAT0 = 32'h8000_0001;
  localparam logic [31:0] PAT1 = 32'h7F3C_A5E1;
  localparam logic [31:0] PAT2 = 32'hF0F0_1234;

  task automatic t_nop_r9();
    apply("R9", 6'h00, 5'd0, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic t_sll_r1();
    for (int n = 0; n < 32; n++) apply("R1", 6'h00, 5'(n), 1'b0, 32'h0, PAT1);
    apply("R1", 6'h00, 5'd31, 1'b0, 32'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_srl_r2();
    for (int n = 0; n < 32; n++) apply("R2", 6'h02, 5'(n), 1'b0, 32'h0, PAT2);
  endtask

  task automatic t_ror_r3();
    for (int n = 0; n < 32; n++) apply("R3", 6'h02, 5'(n), 1'b1, 32'h0, PAT0);
    apply("R7", 6'h02, 5'd0, 1'b1, 32'h0, PAT1);
  endtask

  task automatic t_sra_r4();
    for (int n = 0; n < 32; n++) begin
      apply("R4", 6'h03, 5'(n), 1'b0, 32'h0, PAT2);
      apply("R4", 6'h03, 5'(n), 1'b0, 32'h0, PAT1);
    end
  endtask

  task automatic t_var_r5();
    for (int n = 0; n < 32; n++) begin
      apply("R5", 6'h04, 5'd0, 1'b0, {27'h5A5_A5A5, 5'(n)}, PAT1);
      apply("R5", 6'h06, 5'd0, 1'b0, {27'h7FF_FFFF, 5'(n)}, PAT2);
      apply("R5", 6'h07, 5'd0, 1'b0, {27'h123_4567, 5'(n)}, PAT2);
    end
  endtask

  task automatic t_rotv_r6();
    for (int n = 0; n < 32; n++) apply("R6", 6'h06, 5'd1, 1'b0, 32'(n), PAT1);
    apply("R7", 6'h06, 5'd1, 1'b0, 32'hFFFF_FFE0, PAT2);
  endtask

  task automatic t_invalid_r8();
    for (int f = 0; f < 64; f++) apply("R8", 6'(f), 5'd9, 1'b1, 32'h3, PAT2);
  endtask

  task automatic t_ignored_r10();
    apply("R10", 6'h00, 5'd4, 1'b1, 32'hFFFF_FFFF, PAT1);
    apply("R10", 6'h03, 5'd4, 1'b1, 32'hFFFF_FFFF, PAT2);
    apply("R10", 6'h04, 5'd31, 1'b1, 32'd3, PAT1);
    apply("R10", 6'h07, 5'd17, 1'b1, 32'd3, PAT2);
    apply("R10", 6'h06, 5'd30, 1'b1, 32'd3, PAT1);
    apply("R10", 6'h06, 5'd31, 1'b0, 32'd3, PAT1);
  endtask

  initial begin
    funct = '0; sa = '0; rs_rot = 1'b0; rs_val = '0; rt_val = '0;
    repeat (2) @(negedge clk);
    t_nop_r9();
    t_sll_r1();
    t_srl_r2();
    t_ror_r3();
    t_sra_r4();
    t_var_r5();
    t_rotv_r6();
    t_invalid_r8();
    t_ignored_r10();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule